// File: doc/BRIEF.md
# Seven-Phase Accumulator Processor

This block is a small 8-bit processor built around a single accumulator. It talks to one byte-wide read/write memory through a single address port, and every instruction occupies two consecutive bytes: an opcode followed by an address. Each instruction takes seven clock cycles. The phases run in a fixed order that shares the one memory port between three uses: fetching the opcode, fetching the address byte, and then either reading a data operand or writing the accumulator back.

The arithmetic and logic instructions take their second operand from the memory location named by the address byte. A store instruction writes the accumulator to that location. A conditional branch adds the address byte, read as a signed offset, to the program counter when the accumulator is zero. The offset is applied when the program counter has been stepped only once, so the branch target is the address of the instruction plus one plus the offset. An offset of 0xFF therefore makes the branch jump back to itself, which parks the processor when the accumulator is zero.

The reset input is asserted asynchronously. It is released synchronously, through a synchronizer two stages deep.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, and for the two clock cycles after it is released, mem_addr is 0x00 and mem_we is 0. The first opcode is then fetched from address 0x00.
- R2: In phase 1 mem_addr equals the program counter, and the byte read there becomes the opcode. In phase 3 mem_addr equals the program counter plus one, and the byte read there becomes the address byte.
- R3: In phases 4, 5 and 6 mem_addr equals the address byte of the current instruction.
- R4: In phase 5 the accumulator is updated from the operand read in phase 4, with 8-bit wrap. The opcodes are: 0x01 loads NOT acc; 0x02 loads acc AND operand; 0x03 loads acc OR operand; 0x04 loads acc plus operand; 0x05 loads the operand.
- R5: Opcode 0x00, opcode 0x06, opcode 0x07 and every opcode from 0x08 to 0xFF leave the accumulator unchanged.
- R6: For opcode 0x06, mem_we is 1 in phase 6, and mem_wdata equals the accumulator at that time.
- R7: mem_we is 0 in every phase other than phase 6, and in phase 6 of every opcode other than 0x06.
- R8: An instruction that does not branch places the next instruction at its own address plus two, wrapping at 256.
- R9: Opcode 0x07 with a zero accumulator moves the program counter to the instruction address plus one plus the address byte. The address byte is read as a two's-complement offset, and the sum wraps at 8 bits.
- R10: Opcode 0x07 with a non-zero accumulator behaves like a non-branching instruction.
- R11: Opcode 0x07 with offset 0xFF and a zero accumulator fetches the same instruction again, every seven cycles.
- R12: The phases follow the order 1 to 7 and then return to 1, one clock cycle each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 8 | Memory address |
| mem_rdata | input | 8 | Read data, which must be valid in the same cycle as mem_addr |
| mem_wdata | output | 8 | Write data, equal to the accumulator |
| mem_we | output | 1 | Write strobe, sampled on the rising clock edge |

## Verification
The assertions check a set of local rules on every cycle:
- the write strobe is confined to phase 6 of a store;
- the written data is the accumulator;
- the address port follows the address register in the operand phases;
- the accumulator is held outside phase 5, and held in phase 5 for the opcodes that do not change it;
- the program counter steps by one in phase 2;
- a taken branch adds the offset;
- the phases wrap from 7 back to 1.

Two things can only be shown by the bench scenarios, which run a program end to end. The first is that the operand bytes actually produce the right ALU results. The second is the overall flow of a program: the branch is skipped on a non-zero accumulator and taken forwards and backwards, unknown opcodes act as no-ops, the processor parks on a self-branch, and a reset taken mid-program restarts cleanly.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    PH_CODE  = 3'd0,
    PH_INC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_OPND  = 3'd3,
    PH_EXEC  = 3'd4,
    PH_STORE = 3'd5,
    PH_NEXT  = 3'd6
  } phase_t;

  localparam int OP_NOP   = 0;
  localparam int OP_NOT   = 1;
  localparam int OP_AND   = 2;
  localparam int OP_OR    = 3;
  localparam int OP_ADD   = 4;
  localparam int OP_LOAD  = 5;
  localparam int OP_STORE = 6;
  localparam int OP_BZ    = 7;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    if (phase_q == PH_NEXT) phase_d = PH_CODE;
    else                    phase_d = phase_t'(phase_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_CODE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] code,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result,
  output logic          acc_wr
);

  always_comb begin
    result = acc;
    acc_wr = 1'b1;
    case (code)
      DW'(OP_NOT):  result = ~acc;
      DW'(OP_AND):  result = acc & opnd;
      DW'(OP_OR):   result = acc | opnd;
      DW'(OP_ADD):  result = acc + opnd;
      DW'(OP_LOAD): result = opnd;
      default:      acc_wr = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_cpu_pcu.sv
module acc_cpu_pcu #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          final_en,
  input  logic          take_br,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] pc
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic [AW-1:0] delta;

  always_comb begin
    delta = take_br ? offset : AW'(1);
    pc_d  = pc_q;
    if (step_en)       pc_d = pc_q + AW'(1);
    else if (final_en) pc_d = pc_q + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RST_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);

  localparam int AW = DW;

  logic          rst_n_sync;
  phase_t        phase;
  logic [DW-1:0] code_q, code_d;
  logic [AW-1:0] areg_q, areg_d;
  logic [DW-1:0] opnd_q, opnd_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] alu_res;
  logic          alu_wr;
  logic [AW-1:0] pc;
  logic          code_en, areg_en, opnd_en, acc_en;
  logic          is_store, is_bz, acc_zero, use_areg;

  acc_cpu_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  acc_cpu_seq u_seq (
    .clk(clk), .rst_n(rst_n_sync), .phase(phase)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .code(code_q), .acc(acc_q), .opnd(opnd_q),
    .result(alu_res), .acc_wr(alu_wr)
  );

  assign is_store = (code_q == DW'(OP_STORE));
  assign is_bz    = (code_q == DW'(OP_BZ));
  assign acc_zero = (acc_q == '0);

  acc_cpu_pcu #(.AW(AW)) u_pcu (
    .clk(clk), .rst_n(rst_n_sync),
    .step_en(phase == PH_INC),
    .final_en(phase == PH_NEXT),
    .take_br(is_bz && acc_zero),
    .offset(areg_q),
    .pc(pc)
  );

  assign code_en = (phase == PH_CODE);
  assign areg_en = (phase == PH_ADDR);
  assign opnd_en = (phase == PH_OPND);
  assign acc_en  = (phase == PH_EXEC) && alu_wr;

  always_comb begin
    code_d = code_en ? mem_rdata : code_q;
    areg_d = areg_en ? mem_rdata : areg_q;
    opnd_d = opnd_en ? mem_rdata : opnd_q;
    acc_d  = acc_en  ? alu_res   : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      code_q <= '0;
      areg_q <= '0;
      opnd_q <= '0;
      acc_q  <= '0;
    end else begin
      code_q <= code_d;
      areg_q <= areg_d;
      opnd_q <= opnd_d;
      acc_q  <= acc_d;
    end
  end

  assign use_areg  = (phase == PH_OPND) || (phase == PH_EXEC) || (phase == PH_STORE);
  assign mem_addr  = use_areg ? areg_q : pc;
  assign mem_wdata = acc_q;
  assign mem_we    = (phase == PH_STORE) && is_store;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input phase_t        phase,
  input logic [DW-1:0] code,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] areg,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we
);

  AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_STORE) && (code == DW'(OP_STORE))); // R7

  AST_WDATA_IS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc)); // R6

  AST_OPND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPND || phase == PH_EXEC || phase == PH_STORE) |-> (mem_addr == areg)); // R3

  AST_ACC_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EXEC) |=> $stable(acc)); // R4

  AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && !(code inside {DW'(OP_NOT), DW'(OP_AND), DW'(OP_OR), DW'(OP_ADD), DW'(OP_LOAD)}))
    |=> $stable(acc)); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INC) |=> (pc == DW'($past(pc) + 1'b1))); // R8

  AST_BRANCH_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NEXT && code == DW'(OP_BZ) && acc == '0) |=> (pc == DW'($past(pc) + $past(areg)))); // R9

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NEXT) |=> (phase == PH_CODE)); // R12

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .phase(phase), .code(code_q), .acc(acc_q),
  .areg(areg_q), .pc(pc), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;

  logic       clk;
  logic       rst_n;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic       mem_we;

  logic [7:0] mem [256];
  logic [7:0] mm  [256];

  int n_cmp, n_bad, cyc, rel;
  bit done;

  int mph, mpc, macc, mcode, mar, mop;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %02h expected %02h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    mph = 1; mpc = 0; macc = 0; mcode = 0; mar = 0; mop = 0;
  endtask

  // behavioural reference, one phase per clock
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rel = 0;
      model_reset();
    end else if (rel < 2) begin
      rel++;
    end else begin
      case (mph)
        1: mcode = mm[mpc];
        2: mpc = (mpc + 1) & 255;
        3: mar = mm[mpc];
        4: mop = mm[mar];
        5: case (mcode)
             1: macc = (~macc) & 255;
             2: macc = macc & mop;
             3: macc = macc | mop;
             4: macc = (macc + mop) & 255;
             5: macc = mop;
             default: ;
           endcase
        6: if (mcode == 6) mm[mar] = macc[7:0];
        default: mpc = (mcode == 7 && macc == 0) ? (mpc + mar) & 255 : (mpc + 1) & 255;
      endcase
      mph = (mph == 7) ? 1 : mph + 1;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    int ea;
    int ewe;
    ea  = (mph >= 4 && mph <= 6) ? mar : mpc;
    ewe = (mph == 6 && mcode == 6 && rst_n && rel >= 2) ? 1 : 0;
    if (mph >= 4 && mph <= 6) check("R3 operand address", mem_addr, ea);
    else                      check("R2 R8 R12 fetch address", mem_addr, ea);
    check("R7 write strobe", mem_we, ewe);
    if (ewe == 1) check("R6 write data", mem_wdata, macc);
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input int a, input int op, input int arg);
    mem[a] = op[7:0]; mem[a+1] = arg[7:0];
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put(8'h00, 5, 8'h80); put(8'h02, 2, 8'h81); put(8'h04, 3, 8'h82);
    put(8'h06, 4, 8'h83); put(8'h08, 6, 8'h90); put(8'h0A, 1, 8'h80);
    put(8'h0C, 6, 8'h91); put(8'h0E, 7, 8'h04); put(8'h10, 0, 8'h85);
    put(8'h12, 9, 8'h85); put(8'h14, 6, 8'h95); put(8'h16, 5, 8'h84);
    put(8'h18, 7, 8'h03); put(8'h1A, 6, 8'h92); put(8'h1C, 5, 8'h85);
    put(8'h1E, 4, 8'h83); put(8'h20, 6, 8'h93); put(8'h22, 5, 8'h84);
    put(8'h24, 7, 8'h05); put(8'h26, 7, 8'hFF); put(8'h28, 6, 8'h94);
    put(8'h2A, 7, 8'hFB);
    mem[8'h80] = 8'h3C; mem[8'h81] = 8'h0F; mem[8'h82] = 8'hF0;
    mem[8'h83] = 8'h05; mem[8'h84] = 8'h00; mem[8'h85] = 8'hFF;
    mem[8'h92] = 8'h55; mem[8'h94] = 8'hAA;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
  endtask

  task automatic check_results();
    check("R4 AND/OR/ADD wrap result", mem[8'h90], 8'h01);
    check("R4 NOT result", mem[8'h91], 8'hFE);
    check("R5 NOP and unknown opcode keep acc", mem[8'h95], 8'hFE);
    check("R9 forward branch skips store", mem[8'h92], 8'h55);
    check("R10 untaken branch continues", mem[8'h93], 8'h04);
    check("R9 backward branch skips store", mem[8'h94], 8'hAA);
    while (mph != 1) @(negedge clk);
    check("R11 parked on self branch", mem_addr, 8'h26);
    repeat (7) @(negedge clk);
    check("R11 parked after one more instruction", mem_addr, 8'h26);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; rel = 0; done = 0;
    model_reset();
    rst_n = 1'b0;
    load_prog();
    repeat (3) @(negedge clk);
    check("R1 reset address", mem_addr, 0);
    check("R1 reset strobe", mem_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 held address after release", mem_addr, 0);
    repeat (300) @(negedge clk);
    check_results();

    // reset in the middle of a program, then run it again
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    load_prog();
    @(negedge clk);
    check("R1 mid-run reset address", mem_addr, 0);
    check("R1 mid-run reset strobe", mem_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    load_prog();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (320) @(negedge clk);
    check_results();

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule